// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block runs one bus cycle at a time on an 8-bit asynchronous NAND flash interface. A host raises a request with a cycle kind (command byte, address byte, data write or data read) and a byte value. The sequencer then walks the flash pins through four timed phases: setup, strobe-low, hold and a ready-sample wait. It ends the cycle with a one-clock done pulse, and for a read it also returns the captured byte.

All phase lengths come from a 32-bit timing word. The lower half times read cycles and the upper half times every other kind. A chip-enable force input keeps the device selected between cycles. The ready/busy pin is passed through a two-flop synchroniser, shown on a status output, and used to hold done back while the device is busy. A synchronous software reset input returns the sequencer to idle.

The state machine has these states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`: drives control lines and data ahead of the strobe.
- `ST_STROBE`: holds WE# or RE# low.
- `ST_HOLD`: keeps control lines and data after the strobe.
- `ST_RBWAIT`: the ready-sample delay.
- `ST_FINISH`: waits for synchronised ready and pulses done.

The state machine has these transitions:
- IDLE to SETUP when a request is present.
- SETUP to STROBE, and STROBE to HOLD, when the phase timer expires.
- HOLD to RBWAIT when the wait code is non-zero, otherwise HOLD to FINISH.
- RBWAIT to FINISH when the timer expires.
- FINISH to IDLE once ready is seen.
- Any state to IDLE on software reset.

Top module: `nand_cycle_seq`

## Requirements
- R1: The timing word is split into 4-bit codes. Bits [3:0], [7:4] and [11:8] give read setup, read hold and read strobe width. Bits [19:16], [23:20] and [27:24] give the same three for command, address and write cycles. A code n lasts n+1 clocks, and the strobe starts on the clock after setup ends.
- R2: Bits [15:12] give the read ready-sample wait and bits [31:28] give the write ready-sample wait. A code n gives a wait of 2*n clocks, and a code of 0 skips the wait.
- R3: The phases run in the order setup, strobe, hold, wait. With ready present, done asserts s+p+h+2w+4 clocks after the edge that accepts the request, counting sampling points. done is high for exactly one clock.
- R4: Kind encoding is 0 = command, 1 = address, 2 = write data, 3 = read data. CLE is high for the whole setup, strobe and hold span of a command cycle. ALE is high for the same span of an address cycle. Both are low in every other case.
- R5: For kinds 0, 1 and 2, the data output enable is high from the start of setup to the end of hold, and the bus carries the request byte latched at acceptance. In read cycles the enable stays low.
- R6: In a read cycle, RE# is low only during the strobe phase. The byte on the data input at the RE# rising edge appears on rd_data and is held there.
- R7: done is not given while the synchronised ready is 0. It follows two clocks after ready/busy returns high.
- R8: ready_stat follows the ready/busy pin (1 = ready) through two flops, so it changes two clock edges after the pin does.
- R9: Chip enable (active low) is asserted for the whole cycle. Between cycles it is asserted exactly when ce_force is 1.
- R10: A software reset pulse aborts a cycle. On the next clock the strobes and output enable are released, chip enable follows ce_force, and no done follows.
- R11: A request raised while a cycle is running is ignored. The running cycle completes unchanged and no second cycle starts.
- R12: After reset the strobes and CLE/ALE are inactive, the output enable is low, done is 0, rd_data is 0 and chip enable is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset to idle |
| ce_force | input | 1 | Hold chip enable active between cycles |
| timing | input | 32 | Phase timing word |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | Cycle kind (0 cmd, 1 addr, 2 write, 3 read) |
| req_data | input | 8 | Byte to drive on the bus |
| rd_data | output | 8 | Byte captured by the last read cycle |
| done | output | 1 | One-clock cycle completion pulse |
| ready_stat | output | 1 | Synchronised ready/busy, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 4-bit timing codes and two synchroniser stages. With 4-bit codes, every value of every field can be swept one at a time for both halves of the timing word, including codes 0 and 15, and each cycle still finishes within about eighty clocks. The sweep also checks the all-zero and all-ones timing words on every cycle kind. Further directed runs cover a busy device, a software reset in the middle of a cycle, and requests raised during a running cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WDATA = 2'd2,
        KIND_RDATA = 2'd3
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RBWAIT,
        ST_FINISH
    } seq_state_t;

    // One half of the timing word; first member is most significant.
    typedef struct packed {
        logic [FIELD_W-1:0] rb_wait;
        logic [FIELD_W-1:0] pulse;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } phase_codes_t;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          ce_force,
    input  logic [31:0]   timing,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_data,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          ready_stat,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [DW-1:0] nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_in,
    input  logic          nand_rb
);
    localparam int HALF_W = 4 * FIELD_W;
    localparam int CW     = FIELD_W + 2;

    seq_state_t   state_q, state_d;
    cyc_kind_t    kind_q;
    logic [DW-1:0] data_q, rd_q;
    logic         tmr_load, tmr_expired, rb_ready;
    logic [CW-1:0] tmr_val;
    phase_codes_t rd_codes, wr_codes, acc_codes, cur_codes;
    logic         on_bus;

    assign rd_codes  = phase_codes_t'(timing[HALF_W-1:0]);
    assign wr_codes  = phase_codes_t'(timing[2*HALF_W-1:HALF_W]);
    assign acc_codes = (cyc_kind_t'(req_kind) == KIND_RDATA) ? rd_codes : wr_codes;
    assign cur_codes = (kind_q == KIND_RDATA) ? rd_codes : wr_codes;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nand_rb), .sync_out(rb_ready)
    );

    nand_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_expired)
    );

    // Next-state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = CW'(acc_codes.setup);
            end
            ST_SETUP: if (tmr_expired) begin
                state_d  = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CW'(cur_codes.pulse);
            end
            ST_STROBE: if (tmr_expired) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(cur_codes.hold);
            end
            ST_HOLD: if (tmr_expired) begin
                if (cur_codes.rb_wait == '0) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d  = ST_RBWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'({cur_codes.rb_wait, 1'b0}) - CW'(1);
                end
            end
            ST_RBWAIT: if (tmr_expired) state_d = ST_FINISH;
            ST_FINISH: if (rb_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (soft_rst) begin
            state_d  = ST_IDLE;
            tmr_load = 1'b0;
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_CMD;
            data_q  <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid && !soft_rst) begin
                kind_q <= cyc_kind_t'(req_kind);
                data_q <= req_data;
            end
            if (state_q == ST_STROBE && tmr_expired && kind_q == KIND_RDATA && !soft_rst)
                rd_q <= nand_dq_in;
        end
    end

    // Outputs
    always_comb begin
        on_bus      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        nand_ce_n   = !(ce_force || state_q != ST_IDLE);
        nand_cle    = on_bus && kind_q == KIND_CMD;
        nand_ale    = on_bus && kind_q == KIND_ADDR;
        nand_we_n   = !(state_q == ST_STROBE && kind_q != KIND_RDATA);
        nand_re_n   = !(state_q == ST_STROBE && kind_q == KIND_RDATA);
        nand_dq_oe  = on_bus && kind_q != KIND_RDATA;
        nand_dq_out = data_q;
        done        = (state_q == ST_FINISH) && rb_ready;
        rd_data     = rd_q;
        ready_stat  = rb_ready;
    end

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R5
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_dq_oe && !nand_re_n));
    // R4
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R7
    done_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready_stat);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    ce_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    // R10
    soft_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (nand_we_n && nand_re_n && !nand_dq_oe && !done));
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re_n |=> $stable(rd_data));
endmodule

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, ce_force = 1'b0, req_valid = 1'b0, nand_rb = 1'b1;
    logic [31:0] timing = '0;
    logic [1:0] req_kind = '0;
    logic [7:0] req_data = '0, rd_pattern = '0;
    logic [7:0] rd_data, nand_dq_out, nand_dq_in;
    logic done, ready_stat, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    assign nand_dq_in = nand_re_n ? 8'h00 : rd_pattern;

    nand_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ce_force(ce_force),
        .timing(timing), .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
        .rd_data(rd_data), .done(done), .ready_stat(ready_stat), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            wrap_up();
        end
    end

    task automatic run_cycle(input int kind, input logic [7:0] data, input logic [31:0] tmg,
                             input logic [7:0] rdval, input bit inject);
        int base, s, h, p, w, n, we_c, re_c, oe_c, cle_c, ale_c, ce_hi, bad_dq, first_lo, span;
        bit got;
        base = (kind == 3) ? 0 : 16;
        s = tmg[base +: 4]; h = tmg[base+4 +: 4]; p = tmg[base+8 +: 4]; w = tmg[base+12 +: 4];
        span = s + p + h + 3;
        n = 0; we_c = 0; re_c = 0; oe_c = 0; cle_c = 0; ale_c = 0; ce_hi = 0; bad_dq = 0;
        first_lo = 0; got = 0;
        @(negedge clk);
        timing = tmg; req_valid = 1'b1; req_kind = 2'(kind); req_data = data; rd_pattern = rdval;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3; req_data = ~data;
        for (int i = 0; i < 400 && !got; i++) begin
            n++;
            if (inject && n == 3) begin req_valid = 1'b1; req_kind = (kind == 3) ? 2'd0 : 2'd3; end
            if (inject && n == 4) req_valid = 1'b0;
            if (!nand_we_n) we_c++;
            if (!nand_re_n) re_c++;
            if ((!nand_we_n || !nand_re_n) && first_lo == 0) first_lo = n;
            if (nand_dq_oe) begin oe_c++; if (nand_dq_out != data) bad_dq++; end
            if (nand_cle) cle_c++;
            if (nand_ale) ale_c++;
            if (nand_ce_n) ce_hi++;
            if (done) got = 1; else @(negedge clk);
        end
        check(got && n == s + p + h + 2*w + 4, "R3 latency", n, s + p + h + 2*w + 4);
        check((kind == 3 ? re_c : we_c) == p + 1, "R1 strobe width", kind == 3 ? re_c : we_c, p + 1);
        check((kind == 3 ? we_c : re_c) == 0, "R6 other strobe idle", kind == 3 ? we_c : re_c, 0);
        check(first_lo == s + 2, "R1 setup length", first_lo, s + 2);
        check(oe_c == (kind == 3 ? 0 : span), "R5 drive span", oe_c, kind == 3 ? 0 : span);
        check(bad_dq == 0, "R5 bus value", bad_dq, 0);
        check(cle_c == (kind == 0 ? span : 0), "R4 CLE span", cle_c, kind == 0 ? span : 0);
        check(ale_c == (kind == 1 ? span : 0), "R4 ALE span", ale_c, kind == 1 ? span : 0);
        check(ce_hi == 0, "R9 CE during cycle", ce_hi, 0);
        if (kind == 3) check(rd_data == rdval, "R6 read capture", rd_data, rdval);
        @(negedge clk);
        check(!done, "R3 done pulse", done, 0);
        if (inject) begin
            for (int i = 0; i < 5; i++) begin
                check(!done && nand_we_n && nand_re_n, "R11 no second cycle", done, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int k;
        logic [31:0] base_t, t;
        // R12 reset state
        repeat (3) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R12 pins", nand_ce_n, 1);
        check(!nand_dq_oe && !done, "R12 oe/done", nand_dq_oe, 0);
        check(rd_data == 8'h00, "R12 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8 synchroniser latency
        nand_rb = 1'b0;
        @(negedge clk); check(ready_stat == 1'b1, "R8 one edge", ready_stat, 1);
        @(negedge clk); check(ready_stat == 1'b0, "R8 two edges", ready_stat, 0);
        nand_rb = 1'b1;
        @(negedge clk); check(ready_stat == 1'b0, "R8 rise one edge", ready_stat, 0);
        @(negedge clk); check(ready_stat == 1'b1, "R8 rise two edges", ready_stat, 1);

        // R9 forced chip enable while idle
        ce_force = 1'b1; @(negedge clk);
        check(nand_ce_n == 1'b0, "R9 forced", nand_ce_n, 0);
        ce_force = 1'b0; @(negedge clk);
        check(nand_ce_n == 1'b1, "R9 released", nand_ce_n, 1);

        // R1 R2 field sweep: each field of each half over all codes
        base_t = 32'h1021_1021;
        for (int dir = 0; dir < 2; dir++)
            for (int f = 0; f < 4; f++)
                for (int v = 0; v < 16; v++) begin
                    t = base_t;
                    t[dir*16 + f*4 +: 4] = 4'(v);
                    k = (dir == 0) ? 3 : (v % 3);
                    run_cycle(k, 8'(v * 17) ^ 8'(f), t, 8'hA5 ^ 8'(v), 1'b0);
                end

        // Corner timing words on every kind (R2 zero wait, max codes)
        for (int kk = 0; kk < 4; kk++) begin
            run_cycle(kk, 8'h3C, 32'h0000_0000, 8'h5A, 1'b0);
            run_cycle(kk, 8'hC3, 32'hFFFF_FFFF, 8'h96, 1'b0);
            run_cycle(kk, 8'h81, 32'h3C5A_96E1, 8'h7E, 1'b0);
        end

        // R11 requests during a running cycle
        run_cycle(0, 8'h70, 32'h2345_2345, 8'h00, 1'b1);
        run_cycle(3, 8'h00, 32'h2345_2345, 8'hE7, 1'b1);

        // R7 busy device holds done back
        nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        timing = 32'h0; req_kind = 2'd2; req_data = 8'h11; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        k = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) k++;
            @(negedge clk);
        end
        check(k == 0, "R7 no done while busy", k, 0);
        nand_rb = 1'b1;
        k = 0;
        for (int i = 0; i < 6 && !done; i++) begin @(negedge clk); k++; end
        check(done && k == 2, "R7 done after ready", k, 2);
        repeat (3) @(negedge clk);

        // R10 software reset mid-cycle
        timing = 32'hFFFF_FFFF; req_kind = 2'd0; req_data = 8'h55; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (18) @(negedge clk);
        check(!nand_we_n, "R10 in strobe before reset", nand_we_n, 0);
        soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        check(nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle, "R10 pins released", nand_we_n, 1);
        check(nand_ce_n == 1'b1, "R10 chip enable released", nand_ce_n, 1);
        k = 0;
        for (int i = 0; i < 100; i++) begin
            if (done || !nand_we_n) k++;
            @(negedge clk);
        end
        check(k == 0, "R10 no done after abort", k, 0);

        wrap_up();
    end
endmodule